// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode controller of a single-wire LIN bus transceiver. It tracks the power mode of the transceiver: unpowered, sleep, standby or normal. It takes the asynchronous enable pin, the supply-undervoltage flag and two wake flags as inputs. The wake flags are one-cycle pulses that the analog wake filters have already qualified, one for a local switch and one for a bus wake. From the mode it decodes the controls of the analog front end: transmitter enable, receive-path enable, the termination choice and the regulator-inhibit switch. It also decodes the open-drain pull on RXD and the strong pulldown on TXD that reports the wake source.

In normal mode the receiver output passes bus data to RXD. In standby, RXD is held low to tell the host that a wake-up has happened. TXD is pulled down strongly only when a local wake caused that standby. A host leaves sleep or standby by raising the enable pin, and enters sleep by lowering it while in normal mode. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted or `uv_i` is high, the block is unpowered. All outputs are 0, which includes `term_sel_o` = 2'b00, meaning no termination.
- R2: Leaving unpowered happens on the first clock edge at which `uv_i` is low and at least SYNC_STAGES edges have passed since reset. The target is normal if the synchronized enable is high and standby if it is low.
- R3: In sleep or standby, a high level on `en_i` enters normal mode on the third rising clock edge after the change. Two edges are taken by the synchronizer and one by the mode register.
- R4: In normal mode, a low level on `en_i` enters sleep with the same three-edge latency.
- R5: A pulse on `wake_bus_i` or `wake_local_i` while in sleep moves the block to standby on the next edge. Wake pulses in any other mode change nothing.
- R6: In normal mode the outputs are as follows. `tx_en_o`=1, `rx_path_en_o`=1, `inh_on_o`=1, `term_sel_o`=2'b10 (slave termination), `txd_pd_o`=0. `rxd_low_o` is the inverse of `rx_bus_i`, so bus dominant (0) pulls RXD low.
- R7: In standby the outputs are as follows. `tx_en_o`=0, `rx_path_en_o`=0, `rxd_low_o`=1, `inh_on_o`=1, `term_sel_o`=2'b10.
- R8: In sleep the outputs are as follows. `tx_en_o`=0, `rx_path_en_o`=0, `rxd_low_o`=0 (released), `inh_on_o`=0 (high impedance), `term_sel_o`=2'b01 (weak pullup only), `txd_pd_o`=0.
- R9: `txd_pd_o` is 1 only in a standby that a local wake entered. If both wake pulses arrive in the same cycle, the bus wake wins and `txd_pd_o` stays 0. The wake source is forgotten on entry to normal and in unpowered.
- R10: `uv_i` high in any mode forces unpowered on the next clock edge.
- R11: In sleep, if the synchronized enable is high in the same cycle as a wake pulse, the enable takes precedence and the block enters normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-up reset, active low |
| en_i | input | 1 | Enable pin, asynchronous |
| wake_local_i | input | 1 | Qualified one-cycle local wake pulse |
| wake_bus_i | input | 1 | Qualified one-cycle bus wake pulse |
| uv_i | input | 1 | Supply at or below undervoltage threshold |
| rx_bus_i | input | 1 | Receiver comparator output, 1 = recessive |
| tx_en_o | output | 1 | Bus driver enable |
| rx_path_en_o | output | 1 | Normal receive path select |
| term_sel_o | output | 2 | Termination: 00 none, 01 weak pullup, 10 slave |
| inh_on_o | output | 1 | Regulator-inhibit switch on (0 = high impedance) |
| rxd_low_o | output | 1 | Pull the open-drain RXD output low |
| txd_pd_o | output | 1 | Strong pulldown on TXD (local wake source) |

## Verification
Every output is decoded from the registered mode and wake source, so a wrong internal state shows at the ports in the same cycle it is taken. A wrong mode changes the termination code, the inhibit switch and RXD together. A wrong wake source shows only on `txd_pd_o` during standby, and only until normal mode is entered. The synchronizer latency is checked at the ports by observing that the mode has not yet moved two edges after an enable change and has moved on the third.

// File: rtl/lin_mc_pkg.sv
package lin_mc_pkg;
  typedef enum logic [1:0] {
    MODE_UNPWR = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STBY  = 2'd2,
    MODE_NORM  = 2'd3
  } lin_mode_e;

  typedef enum logic {
    SRC_BUS   = 1'b0,
    SRC_LOCAL = 1'b1
  } wake_src_e;

  localparam logic [1:0] TERM_NONE  = 2'b00;
  localparam logic [1:0] TERM_WEAK  = 2'b01;
  localparam logic [1:0] TERM_SLAVE = 2'b10;
endpackage

// File: rtl/lin_en_sync.sv
module lin_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic ready_o
);
  localparam int CW = $clog2(STAGES + 1);
  localparam logic [CW-1:0] FULL = CW'(STAGES);

  logic [STAGES-1:0] stg;
  logic [CW-1:0]     fill_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= 1'b0;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  // counts edges since reset until the chain holds real samples
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              fill_q <= '0;
    else if (fill_q != FULL) fill_q <= fill_q + 1'b1;

  assign q_o     = stg[STAGES-1];
  assign ready_o = (fill_q == FULL);
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_s_i,
  input  logic      sync_ready_i,
  input  logic      uv_i,
  input  logic      wake_bus_i,
  input  logic      wake_local_i,
  output lin_mode_e mode_o,
  output wake_src_e src_o
);
  lin_mode_e mode_q, mode_d;
  wake_src_e src_q, src_d;

  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    if (uv_i) begin
      mode_d = MODE_UNPWR;
      src_d  = SRC_BUS;
    end else begin
      unique case (mode_q)
        MODE_UNPWR: if (sync_ready_i) begin
          mode_d = en_s_i ? MODE_NORM : MODE_STBY;
          src_d  = SRC_BUS;
        end
        MODE_SLEEP: if (en_s_i) begin
          mode_d = MODE_NORM;
          src_d  = SRC_BUS;
        end else if (wake_bus_i || wake_local_i) begin
          mode_d = MODE_STBY;
          src_d  = wake_bus_i ? SRC_BUS : SRC_LOCAL;
        end
        MODE_STBY: if (en_s_i) begin
          mode_d = MODE_NORM;
          src_d  = SRC_BUS;
        end
        MODE_NORM: if (!en_s_i) mode_d = MODE_SLEEP;
        default: mode_d = MODE_UNPWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= MODE_UNPWR;
      src_q  <= SRC_BUS;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
    end

  assign mode_o = mode_q;
  assign src_o  = src_q;
endmodule

// File: rtl/lin_mode_outdec.sv
module lin_mode_outdec
  import lin_mc_pkg::*;
(
  input  lin_mode_e   mode_i,
  input  wake_src_e   src_i,
  input  logic        rx_bus_i,
  output logic        tx_en_o,
  output logic        rx_path_en_o,
  output logic [1:0]  term_sel_o,
  output logic        inh_on_o,
  output logic        rxd_low_o,
  output logic        txd_pd_o
);
  always_comb begin
    tx_en_o      = 1'b0;
    rx_path_en_o = 1'b0;
    term_sel_o   = TERM_NONE;
    inh_on_o     = 1'b0;
    rxd_low_o    = 1'b0;
    txd_pd_o     = 1'b0;
    unique case (mode_i)
      MODE_NORM: begin
        tx_en_o      = 1'b1;
        rx_path_en_o = 1'b1;
        term_sel_o   = TERM_SLAVE;
        inh_on_o     = 1'b1;
        rxd_low_o    = ~rx_bus_i;
      end
      MODE_STBY: begin
        term_sel_o = TERM_SLAVE;
        inh_on_o   = 1'b1;
        rxd_low_o  = 1'b1;
        txd_pd_o   = (src_i == SRC_LOCAL);
      end
      MODE_SLEEP: term_sel_o = TERM_WEAK;
      default: ;
    endcase
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       wake_local_i,
  input  logic       wake_bus_i,
  input  logic       uv_i,
  input  logic       rx_bus_i,
  output logic       tx_en_o,
  output logic       rx_path_en_o,
  output logic [1:0] term_sel_o,
  output logic       inh_on_o,
  output logic       rxd_low_o,
  output logic       txd_pd_o
);
  import lin_mc_pkg::*;

  logic      en_s, sync_ready;
  lin_mode_e mode;
  wake_src_e src;

  lin_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(en_i), .q_o(en_s), .ready_o(sync_ready)
  );

  lin_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s_i(en_s), .sync_ready_i(sync_ready),
    .uv_i(uv_i), .wake_bus_i(wake_bus_i), .wake_local_i(wake_local_i),
    .mode_o(mode), .src_o(src)
  );

  lin_mode_outdec u_dec (
    .mode_i(mode), .src_i(src), .rx_bus_i(rx_bus_i),
    .tx_en_o(tx_en_o), .rx_path_en_o(rx_path_en_o), .term_sel_o(term_sel_o),
    .inh_on_o(inh_on_o), .rxd_low_o(rxd_low_o), .txd_pd_o(txd_pd_o)
  );
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_i,
  input logic       wake_local_i,
  input logic       wake_bus_i,
  input logic       tx_en_o,
  input logic       rx_path_en_o,
  input logic [1:0] term_sel_o,
  input logic       inh_on_o,
  input logic       rxd_low_o,
  input logic       txd_pd_o
);
  // R1
  uv_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (term_sel_o == 2'b00 && !inh_on_o && !tx_en_o && !rxd_low_o));

  // R10
  uv_drops_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && uv_i) |=> !tx_en_o);

  // R6
  normal_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (inh_on_o && rx_path_en_o && term_sel_o == 2'b10 && !txd_pd_o));

  // R7
  standby_rxd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_on_o && !tx_en_o) |-> (rxd_low_o && term_sel_o == 2'b10));

  // R8
  sleep_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_sel_o == 2'b01) |-> (!inh_on_o && !tx_en_o && !rxd_low_o && !txd_pd_o));

  // R9
  local_src_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_pd_o) |-> $past(wake_local_i && !wake_bus_i));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .wake_local_i(wake_local_i),
  .wake_bus_i(wake_bus_i), .tx_en_o(tx_en_o), .rx_path_en_o(rx_path_en_o),
  .term_sel_o(term_sel_o), .inh_on_o(inh_on_o), .rxd_low_o(rxd_low_o),
  .txd_pd_o(txd_pd_o)
);

// File: tb/lin_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb_top;
  localparam int ST_U = 0, ST_SL = 1, ST_SB = 2, ST_N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, wake_local_i = 1'b0, wake_bus_i = 1'b0, uv_i = 1'b0, rx_bus_i = 1'b1;
  logic tx_en_o, rx_path_en_o, inh_on_o, rxd_low_o, txd_pd_o;
  logic [1:0] term_sel_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lin_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wake_local_i(wake_local_i),
    .wake_bus_i(wake_bus_i), .uv_i(uv_i), .rx_bus_i(rx_bus_i),
    .tx_en_o(tx_en_o), .rx_path_en_o(rx_path_en_o), .term_sel_o(term_sel_o),
    .inh_on_o(inh_on_o), .rxd_low_o(rxd_low_o), .txd_pd_o(txd_pd_o)
  );

  // reference model built from the requirements
  int m_st = ST_U;
  bit m_local = 0;
  bit [1:0] m_en = 2'b00;
  int m_age = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = ST_U; m_local = 0; m_en = 2'b00; m_age = 0;
    end else begin
      if (uv_i) begin
        m_st = ST_U; m_local = 0;                       // R10
      end else begin
        case (m_st)
          ST_U:  if (m_age >= 2) begin m_st = m_en[1] ? ST_N : ST_SB; m_local = 0; end
          ST_SL: if (m_en[1]) begin m_st = ST_N; m_local = 0; end          // R11
                 else if (wake_bus_i || wake_local_i) begin
                   m_st = ST_SB; m_local = !wake_bus_i;
                 end
          ST_SB: if (m_en[1]) begin m_st = ST_N; m_local = 0; end
          default: if (!m_en[1]) m_st = ST_SL;
        endcase
      end
      m_en = {m_en[0], en_i};
      if (m_age < 2) m_age++;
    end
  end

  function automatic logic [6:0] expect_out(int st, bit loc, logic rxb);
    case (st)
      ST_N:  return {1'b1, 1'b1, 2'b10, 1'b1, ~rxb, 1'b0};
      ST_SB: return {1'b0, 1'b0, 2'b10, 1'b1, 1'b1, loc};
      ST_SL: return {1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0};
      default: return 7'b0;
    endcase
  endfunction

  task automatic check(string tag);
    logic [6:0] act, exp;
    act = {tx_en_o, rx_path_en_o, term_sel_o, inh_on_o, rxd_low_o, txd_pd_o};
    exp = expect_out(m_st, m_local, rx_bus_i);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic pulse(bit loc, bit bus, string tag);
    wake_local_i = loc; wake_bus_i = bus;
    step(tag);
    wake_local_i = 0; wake_bus_i = 0;
  endtask

  function automatic string state_tag(int st);
    case (st)
      ST_N: return "R6"; ST_SB: return "R7"; ST_SL: return "R8"; default: return "R1";
    endcase
  endfunction

  initial begin
    int uv_hold;
    @(negedge clk);
    check("R1 reset state");
    step("R1 reset held");
    rst_n = 1;
    repeat (3) step("R2 exit to standby with en low");
    step("R7 standby outputs");
    en_i = 1;
    step("R3 no change after one edge");
    step("R3 no change after two edges");
    step("R3 normal on third edge");
    rx_bus_i = 0; step("R6 rxd follows dominant");
    rx_bus_i = 1; step("R6 rxd follows recessive");
    pulse(1, 1, "R5 wake ignored in normal");
    en_i = 0;
    repeat (3) step("R4 sleep after three edges");
    step("R8 sleep outputs");
    pulse(1, 0, "R5 local wake to standby");
    step("R9 local source pulldown");
    pulse(0, 1, "R5 wake ignored in standby");
    step("R9 source kept");
    en_i = 1; repeat (3) step("R9 cleared on normal");
    en_i = 0; repeat (3) step("R4 back to sleep");
    pulse(1, 1, "R9 bus wins on tie");
    step("R9 no pulldown after tie");
    en_i = 1; repeat (3) step("R3 standby to normal");
    en_i = 0; repeat (3) step("R4 sleep again");
    en_i = 1; step("R11 prep"); step("R11 prep");
    pulse(1, 0, "R11 enable beats wake");
    uv_i = 1; step("R10 uv from normal");
    uv_i = 0; step("R2 recover to normal with en high");
    en_i = 0; repeat (3) step("R4 sleep");
    uv_i = 1; step("R10 uv from sleep");
    uv_i = 0; step("R2 recover to standby with en low");
    step("R9 no pulldown after power-up");

    // constrained random phase
    void'($urandom(32'h1A5C0DE));
    uv_hold = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) en_i = ~en_i;
      if (uv_hold > 0) uv_hold--;
      else if ($urandom_range(199) == 0) uv_hold = $urandom_range(4, 1);
      uv_i = (uv_hold > 0);
      wake_local_i = ($urandom_range(15) == 0);
      wake_bus_i   = ($urandom_range(15) == 0);
      rx_bus_i     = 1'($urandom_range(1));
      step("random");
      if (!(tx_en_o === 1'b0 && m_st == ST_U)) begin
        total++;
        if (expect_out(m_st, m_local, rx_bus_i) !==
            {tx_en_o, rx_path_en_o, term_sel_o, inh_on_o, rxd_low_o, txd_pd_o}) begin
          bad++;
          $display("FAIL %s random state actual=%b expected=%b", state_tag(m_st),
                   {tx_en_o, rx_path_en_o, term_sel_o, inh_on_o, rxd_low_o, txd_pd_o},
                   expect_out(m_st, m_local, rx_bus_i));
        end
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule